// File: doc/BRIEF.md
# User Interrupt Flag Control Unit

This block keeps the per-core flag that enables delivery of user-level interrupts. It also executes the three instructions that act on that flag: clear, set and test. The decode stage presents one instruction at a time as a strobe with a two-bit opcode. Alongside it come the status bits that decide whether the instruction is legal: a control-register enable, a 64-bit-mode indicator, an enclave-active indicator and a transactional-region indicator.

An illegal instruction produces a one-cycle invalid-opcode fault pulse. A clear or set issued inside a transactional region produces a one-cycle transactional-abort pulse. In both cases the flag keeps its value. A legal test returns the flag in the carry position of an arithmetic-flags bundle, with the other flags zero, and as a zero-extended result byte. The interrupt-delivery stage samples the delivery-allowed output at each instruction boundary. A flag change is seen there in the cycle that follows the instruction.

Top module: `uif_ctrl_unit`

## Requirements
- R1: A legal clear (opcode 0) with transactional indicator low makes flagOut 0 in the cycle after the strobe, and a legal set (opcode 1) makes it 1. Legal means cfgEnable=1, longMode=1 and enclaveActive=0.
- R2: deliverOk equals the flag value, and from the cycle after a flag-writing strobe it shows the new value.
- R3: When opcode is 0, 1 or 2 and the instruction is illegal (cfgEnable=0, longMode=0 or enclaveActive=1), faultPulse is 1 in the next cycle. The flag is unchanged, testDone stays 0, and resultFlags and resultByte keep their previous values.
- R4: A legal clear or set with txnActive=1 gives abortPulse=1 in the next cycle and leaves the flag unchanged.
- R5: A legal test (opcode 2) executes whatever txnActive is. It gives testDone=1 in the next cycle, with faultPulse=0 and abortPulse=0, and it does not change the flag.
- R6: A legal test loads resultFlags with bit0=CF equal to the flag before the instruction, and with bit1=PF, bit2=AF, bit3=ZF, bit4=SF and bit5=OF all 0. resultByte equals CF zero-extended.
- R7: In the cycle after synchronous reset, flagOut, deliverOk, faultPulse, abortPulse, testDone, resultFlags and resultByte are all 0.
- R8: When an instruction is both illegal and a clear or set inside a transactional region, only faultPulse is raised and abortPulse stays 0.
- R9: faultPulse, abortPulse and testDone last one cycle. They return to 0 in the next cycle when instValid is low.
- R10: Opcode 3, and any cycle with instValid=0, change no output and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction strobe |
| instOp | input | 2 | Opcode: 0 clear, 1 set, 2 test, 3 reserved |
| cfgEnable | input | 1 | Control-register enable bit |
| longMode | input | 1 | Core is in 64-bit mode |
| enclaveActive | input | 1 | An enclave is executing |
| txnActive | input | 1 | Inside a transactional region |
| flagOut | output | 1 | Current flag value |
| deliverOk | output | 1 | User interrupt delivery allowed at the next boundary |
| faultPulse | output | 1 | Invalid-opcode fault pulse |
| abortPulse | output | 1 | Transactional-abort pulse |
| testDone | output | 1 | A test result was loaded |
| resultFlags | output | 6 | OF, SF, ZF, AF, PF, CF (bit5 to bit0) |
| resultByte | output | 8 | Test result byte, equal to CF |

## Verification
Every cycle, the assertions check four things. Set and clear strobes land in the flag. A fault or abort leaves the flag as it was. A test captures the flag value that held before the instruction. Fault and abort never rise together. They also check that illegal status inputs never produce a write strobe. The bench's sweep alone shows the complete legality-by-opcode outcome table, including the cases with instValid low or opcode 3. Only the sweep shows that an illegal test keeps the earlier result, and that the pulses end after one cycle.

// File: rtl/uif_ctrl_pkg.sv
package uif_ctrl_pkg;
  localparam int OP_W = 2;
  localparam int FLAGS_W = 6;
  localparam int RES_W = 8;

  typedef enum logic [OP_W-1:0] {
    OP_CLEAR = 2'd0,
    OP_SET   = 2'd1,
    OP_TEST  = 2'd2,
    OP_RSVD  = 2'd3
  } uifOp_e;

  typedef struct packed {
    logic doClear;
    logic doSet;
    logic doTest;
    logic raiseFault;
    logic raiseAbort;
  } uifStrobe_t;

  localparam int CF_BIT = 0;
endpackage

// File: rtl/uif_ctrl_decode.sv
module uif_ctrl_decode
  import uif_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            instValid,
  input  logic [OP_W-1:0] instOp,
  input  logic            cfgEnable,
  input  logic            longMode,
  input  logic            enclaveActive,
  input  logic            txnActive,
  output uifStrobe_t      strb
);
  logic legal;
  logic isFlagOp;
  logic isWrite;

  assign legal    = cfgEnable && longMode && !enclaveActive;
  assign isWrite  = (instOp == OP_CLEAR) || (instOp == OP_SET);
  assign isFlagOp = isWrite || (instOp == OP_TEST);

  always_comb begin
    strb = '0;
    if (instValid && isFlagOp) begin
      if (!legal) begin
        strb.raiseFault = 1'b1;              // fault wins over abort
      end else if (isWrite && txnActive) begin
        strb.raiseAbort = 1'b1;
      end else begin
        strb.doClear = (instOp == OP_CLEAR);
        strb.doSet   = (instOp == OP_SET);
        strb.doTest  = (instOp == OP_TEST);
      end
    end
  end

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  p_illegal_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    (instValid && (!cfgEnable || !longMode || enclaveActive)) |-> !(strb.doSet || strb.doClear || strb.doTest));

  p_txn_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    txnActive |-> !(strb.doSet || strb.doClear));
endmodule

// File: rtl/uif_ctrl_datapath.sv
module uif_ctrl_datapath
  import uif_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  uifStrobe_t         strb,
  output logic               flagQ,
  output logic               faultQ,
  output logic               abortQ,
  output logic               doneQ,
  output logic [FLAGS_W-1:0] flagsQ,
  output logic [RES_W-1:0]   byteOut
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flagQ  <= 1'b0;
      faultQ <= 1'b0;
      abortQ <= 1'b0;
      doneQ  <= 1'b0;
      flagsQ <= '0;
    end else begin
      faultQ <= strb.raiseFault;
      abortQ <= strb.raiseAbort;
      doneQ  <= strb.doTest;
      if (strb.doClear) flagQ <= 1'b0;
      else if (strb.doSet) flagQ <= 1'b1;
      if (strb.doTest) begin
        flagsQ         <= '0;
        flagsQ[CF_BIT] <= flagQ;
      end
    end
  end

  assign byteOut = {{(RES_W-1){1'b0}}, flagsQ[CF_BIT]};

  p_set_lands_r1: assert property (@(posedge clk) disable iff (rst)
    strb.doSet |=> flagQ);

  p_clear_lands_r2: assert property (@(posedge clk) disable iff (rst)
    strb.doClear |=> !flagQ);

  p_fault_holds_r3: assert property (@(posedge clk) disable iff (rst)
    faultQ |-> (flagQ == $past(flagQ)));

  p_abort_holds_r4: assert property (@(posedge clk) disable iff (rst)
    abortQ |-> (flagQ == $past(flagQ)));

  p_test_reads_r6: assert property (@(posedge clk) disable iff (rst)
    strb.doTest |=> (flagsQ[CF_BIT] == $past(flagQ)) && (byteOut[RES_W-1:1] == '0));

  p_excl_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !(faultQ && abortQ));
endmodule

// File: rtl/uif_ctrl_unit.sv
module uif_ctrl_unit
  import uif_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instValid,
  input  logic [OP_W-1:0]    instOp,
  input  logic               cfgEnable,
  input  logic               longMode,
  input  logic               enclaveActive,
  input  logic               txnActive,
  output logic               flagOut,
  output logic               deliverOk,
  output logic               faultPulse,
  output logic               abortPulse,
  output logic               testDone,
  output logic [FLAGS_W-1:0] resultFlags,
  output logic [RES_W-1:0]   resultByte
);
  uifStrobe_t strb;
  logic flagQ;

  uif_ctrl_decode uDecode (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .cfgEnable(cfgEnable), .longMode(longMode),
    .enclaveActive(enclaveActive), .txnActive(txnActive), .strb(strb)
  );

  uif_ctrl_datapath uData (
    .clk(clk), .rst(rst), .strb(strb), .flagQ(flagQ),
    .faultQ(faultPulse), .abortQ(abortPulse), .doneQ(testDone),
    .flagsQ(resultFlags), .byteOut(resultByte)
  );

  assign flagOut   = flagQ;
  assign deliverOk = flagQ;
endmodule

// File: tb/uif_ctrl_unit_test.sv
module uif_ctrl_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instValid = 1'b0;
  logic [1:0] instOp = 2'd3;
  logic cfgEnable = 1'b0, longMode = 1'b0, enclaveActive = 1'b0, txnActive = 1'b0;
  logic flagOut, deliverOk, faultPulse, abortPulse, testDone;
  logic [5:0] resultFlags;
  logic [7:0] resultByte;

  int nTests = 0;
  int nFail = 0;
  logic [5:0] expFlags = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  uif_ctrl_unit uut (
    .clk(clk), .rst(rst), .instValid(instValid), .instOp(instOp),
    .cfgEnable(cfgEnable), .longMode(longMode), .enclaveActive(enclaveActive),
    .txnActive(txnActive), .flagOut(flagOut), .deliverOk(deliverOk),
    .faultPulse(faultPulse), .abortPulse(abortPulse), .testDone(testDone),
    .resultFlags(resultFlags), .resultByte(resultByte)
  );

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] op, input logic c,
                       input logic l, input logic e, input logic t);
    @(negedge clk);
    instValid = v; instOp = op; cfgEnable = c; longMode = l;
    enclaveActive = e; txnActive = t;
    @(negedge clk);
    instValid = 1'b0; instOp = 2'd3;
  endtask

  task automatic forceFlag(input logic v);
    issue(1'b1, v ? 2'd1 : 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R1 flag write", flagOut, v);
    check("R2 deliverOk follows", deliverOk, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R7 flagOut", flagOut, 0);
    check("R7 deliverOk", deliverOk, 0);
    check("R7 faultPulse", faultPulse, 0);
    check("R7 abortPulse", abortPulse, 0);
    check("R7 testDone", testDone, 0);
    check("R7 resultFlags", resultFlags, 0);
    check("R7 resultByte", resultByte, 0);

    for (int init = 0; init < 2; init++)
      for (int vld = 0; vld < 2; vld++)
        for (int op = 0; op < 4; op++)
          for (int cond = 0; cond < 16; cond++) begin
            logic c, l, e, t, legal, flagOp, isW;
            logic expFault, expAbort, expDone, expFlag;
            c = cond[0]; l = cond[1]; e = cond[2]; t = cond[3];
            forceFlag(init[0]);
            legal = c && l && !e;
            flagOp = (op != 3) && vld[0];
            isW = (op < 2);
            expFault = flagOp && !legal;
            expAbort = flagOp && legal && isW && t;
            expDone = flagOp && legal && (op == 2);
            expFlag = init[0];
            if (flagOp && legal && isW && !t) expFlag = (op == 1);
            if (expDone) begin expFlags = '0; expFlags[0] = init[0]; end
            issue(vld[0], op[1:0], c, l, e, t);
            if (expFault) check("R3 fault raised", faultPulse, 1);
            else if (!flagOp) check("R10 no fault", faultPulse, 0);
            else check("R5 no fault", faultPulse, 0);
            if (legal && !e && flagOp && isW && t) check("R4 abort raised", abortPulse, 1);
            else if (expFault && isW && t) check("R8 fault wins abort", abortPulse, 0);
            else check("R10 abort idle", abortPulse, expAbort);
            check("R5 testDone", testDone, expDone);
            check("R1 flag value", flagOut, expFlag);
            check("R2 deliverOk", deliverOk, expFlag);
            check("R6 resultFlags", resultFlags, expFlags);
            check("R6 resultByte", resultByte, {7'd0, expFlags[0]});
            @(negedge clk);
            check("R9 fault ends", faultPulse, 0);
            check("R9 abort ends", abortPulse, 0);
            check("R9 done ends", testDone, 0);
            check("R10 flag idle", flagOut, expFlag);
          end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule